// File: doc/BRIEF.md
# Shadowed Up-Count PWM Channel

This block is one pulse-width-modulation channel driven by a free-running up-counter. The counter steps from zero to a programmable period value and then returns to zero, so each PWM frame lasts period+1 clock ticks. The output goes high when the counter matches the active compare-A value and goes low when it matches the active period value. This gives an edge-aligned waveform with a high time of period minus compare-A ticks.

The period, compare-A and compare-B values are written into holding (shadow) registers. The values the logic actually uses are copied from the holding registers only at the edge where the counter wraps to zero. Duty and frequency therefore change only on frame boundaries and never produce a partial frame. Compare B is stored and committed in the same way, but it drives no action on the output.

A run enable freezes the counter and the output level while it is low. Several instances can run side by side, each with its own period and so its own frequency. The counter is never preset from outside and emits no synchronisation pulse.

Top module: `pwm_upcount_chan`

## Requirements
- R1: After a synchronous reset, `count` is 0, `pwm_a` is 0, and all holding and active registers are 0. With the active period at 0, `count` then stays at 0.
- R2: While `run_en` is high, `count` rises by one each clock until it equals the active period, and the next clock returns it to 0. A frame lasts period+1 clocks.
- R3: A period write takes effect only at the next wrap to zero. The frame in progress keeps its old length.
- R4: A compare-A write takes effect only at the next wrap to zero. The frame in progress keeps its old set point.
- R5: When `count` equals the active compare A and differs from the active period, `pwm_a` is 1 from the next clock. With compare A below the period, `pwm_a` is high for period minus compare-A clocks per frame.
- R6: When `count` equals the active period, `pwm_a` is 0 from the next clock, so it is low whenever `count` is 0.
- R7: If compare A equals the period, the clear action wins. If compare A is greater than the period, no set occurs. In both cases `pwm_a` stays 0 for the whole frame.
- R8: A write whose clock edge is itself a wrap edge is not committed at that wrap. The holding register is copied at that edge, before the write lands, so the new value takes effect at the following wrap.
- R9: While `run_en` is low, `count` and `pwm_a` hold their values. No commit occurs.
- R10: Compare-B writes have no effect on `count` or `pwm_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counter run enable; low freezes count and output |
| prd_wr | input | 1 | Write strobe for the period holding register |
| prd_wdata | input | W | Period value to write |
| cmpa_wr | input | 1 | Write strobe for the compare-A holding register |
| cmpa_wdata | input | W | Compare-A value to write |
| cmpb_wr | input | 1 | Write strobe for the compare-B holding register |
| cmpb_wdata | input | W | Compare-B value to write (no output action) |
| count | output | W | Current counter value |
| pwm_a | output | 1 | PWM output A |

## Verification
A wrong active period shows up on `count` as a wrong wrap point within one frame. A commit made at the wrong time shows up as the new value appearing mid-frame, within the same frame as the write. A wrong compare-A value or a wrong priority between set and clear changes the measured high time of `pwm_a` in the first frame that uses the value. Write-on-wrap timing is exposed with the period at 0, where every edge is a wrap, so an early commit moves the first non-zero count one clock earlier.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 3;
    localparam int IDX_PRD  = 0;
    localparam int IDX_CMPA = 1;
    localparam int IDX_CMPB = 2;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } pwm_act_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    output logic [W-1:0] act
);
    typedef struct packed {
        logic [W-1:0] shd;
        logic [W-1:0] act;
    } sreg_t;

    sreg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.shd = wdata;
        end
        // the active copy takes the holding value as it stood before this edge
        if (commit) begin
            s_d.act = s_q.shd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act = s_q.act;

    // R3 / R4: the active value moves only on a commit edge
    a_r3_act_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act));

    // R8: a write landing on a commit edge is not what gets committed
    a_r8_commit_old_shadow: assert property (@(posedge clk) disable iff (rst)
        (commit && wr && (wdata != s_q.shd)) |=> (act != $past(wdata)));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic [W-1:0] prd_act,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tb_t;

    tb_t t_d, t_q;
    logic at_top;

    always_comb begin
        // >= keeps the wrap safe even if the period ever sits below the count
        at_top = (t_q.cnt >= prd_act);
        t_d    = t_q;
        if (run_en) begin
            if (at_top) begin
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt  = t_q.cnt;
    assign wrap = run_en && at_top;

    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (run_en && (cnt < prd_act)) |=> (cnt == W'($past(cnt) + 1'b1)));

    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (run_en && (cnt == prd_act)) |=> (cnt == '0));

    a_r9_count_frozen: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(cnt));
endmodule

// File: rtl/pwm_action.sv
module pwm_action
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] prd_act,
    input  logic [W-1:0] cmpa_act,
    input  logic [W-1:0] cmpb_act,
    output logic         pwm
);
    typedef struct packed {
        logic pwm;
    } act_t;

    act_t     a_d, a_q;
    pwm_act_e evt;

    always_comb begin
        // clear on period match outranks set on compare-A match
        if (cnt == prd_act) begin
            evt = ACT_CLR;
        end else if (cnt == cmpa_act) begin
            evt = ACT_SET;
        end else begin
            evt = ACT_NONE;
        end

        a_d = a_q;
        if (run_en) begin
            unique case (evt)
                ACT_SET:  a_d.pwm = 1'b1;
                ACT_CLR:  a_d.pwm = 1'b0;
                default:  a_d.pwm = a_q.pwm;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign pwm = a_q.pwm;

    a_r5_set_on_cmpa: assert property (@(posedge clk) disable iff (rst)
        (run_en && (cnt == cmpa_act) && (cnt != prd_act)) |=> pwm);

    a_r6_clear_on_prd: assert property (@(posedge clk) disable iff (rst)
        (run_en && (cnt == prd_act)) |=> !pwm);

    a_r9_pwm_frozen: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(pwm));

    a_r10_cmpb_inert: assert property (@(posedge clk) disable iff (rst)
        (run_en && (cnt == cmpb_act) && (cnt != cmpa_act) && (cnt != prd_act))
        |=> $stable(pwm));
endmodule

// File: rtl/pwm_upcount_chan.sv
module pwm_upcount_chan
    import pwm_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         prd_wr,
    input  logic [W-1:0] prd_wdata,
    input  logic         cmpa_wr,
    input  logic [W-1:0] cmpa_wdata,
    input  logic         cmpb_wr,
    input  logic [W-1:0] cmpb_wdata,
    output logic [W-1:0] count,
    output logic         pwm_a
);
    logic [NUM_REGS-1:0]        wr_vec;
    logic [NUM_REGS-1:0][W-1:0] wdata_vec;
    logic [NUM_REGS-1:0][W-1:0] act_vec;
    logic                       wrap;

    always_comb begin
        wr_vec              = '0;
        wdata_vec           = '0;
        wr_vec[IDX_PRD]     = prd_wr;
        wr_vec[IDX_CMPA]    = cmpa_wr;
        wr_vec[IDX_CMPB]    = cmpb_wr;
        wdata_vec[IDX_PRD]  = prd_wdata;
        wdata_vec[IDX_CMPA] = cmpa_wdata;
        wdata_vec[IDX_CMPB] = cmpb_wdata;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_shadow
        pwm_shadow_reg #(.W(W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr_vec[g]),
            .wdata  (wdata_vec[g]),
            .commit (wrap),
            .act    (act_vec[g])
        );
    end

    pwm_timebase #(.W(W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .prd_act (act_vec[IDX_PRD]),
        .cnt     (count),
        .wrap    (wrap)
    );

    pwm_action #(.W(W)) u_act (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .cnt      (count),
        .prd_act  (act_vec[IDX_PRD]),
        .cmpa_act (act_vec[IDX_CMPA]),
        .cmpb_act (act_vec[IDX_CMPB]),
        .pwm      (pwm_a)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> ((count == '0) && !pwm_a));

    a_r6_low_at_zero: assert property (@(posedge clk) disable iff (rst)
        (run_en && (count == act_vec[IDX_PRD])) |=> (!pwm_a && (count == '0)));
endmodule

// File: tb/sim_pwm_upcount_chan.sv
module sim_pwm_upcount_chan;
    localparam int W  = 16;
    localparam int NV = 8;

    // stimulus: period, compare A; expected: frame length, high clocks
    localparam logic [W-1:0] V_PRD [NV] = '{16'd1200, 16'd1400, 16'd800, 16'd9, 16'd9, 16'd9, 16'd9, 16'd0};
    localparam logic [W-1:0] V_CMP [NV] = '{16'd700,  16'd700,  16'd500, 16'd4, 16'd0, 16'd9, 16'd12, 16'd0};
    localparam int           E_PER [NV] = '{1201, 1401, 801, 10, 10, 10, 10, 1};
    localparam int           E_HI  [NV] = '{500,  700,  300, 5,  9,  0,  0,  0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         prd_wr = 1'b0, cmpa_wr = 1'b0, cmpb_wr = 1'b0;
    logic [W-1:0] prd_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0;
    logic [W-1:0] count;
    logic         pwm_a;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_upcount_chan #(.W(W)) u0 (
        .clk(clk), .rst(rst), .run_en(run_en),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
        .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
        .count(count), .pwm_a(pwm_a)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int sel, input logic [W-1:0] v);
        @(negedge clk);
        case (sel)
            0: begin prd_wr = 1'b1;  prd_wdata = v;  end
            1: begin cmpa_wr = 1'b1; cmpa_wdata = v; end
            default: begin cmpb_wr = 1'b1; cmpb_wdata = v; end
        endcase
        @(negedge clk);
        prd_wr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    endtask

    task automatic wait_count(input logic [W-1:0] v);
        while (count != v) @(negedge clk);
    endtask

    task automatic measure(output int per, output int hi);
        wait_count('0);
        per = 0;
        hi  = 0;
        do begin
            per++;
            hi += int'(pwm_a);
            @(negedge clk);
        end while (count != '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int per, hi, mx;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        run_en = 1'b1;
        @(negedge clk);
        check("R1 count after reset", count, 0);
        check("R1 pwm after reset", pwm_a, 0);
        repeat (3) @(negedge clk);
        check("R1 period zero keeps count at 0", count, 0);

        // R8: period 0 means every edge is a wrap edge
        @(negedge clk);
        prd_wr = 1'b1; prd_wdata = 16'd5;
        @(negedge clk);
        prd_wr = 1'b0;
        check("R8 count after write on wrap edge", count, 0);
        @(negedge clk);
        check("R8 count one frame later", count, 0);
        @(negedge clk);
        check("R8 new period committed at following wrap", count, 1);

        // table of frame shapes (R2, R5, R6, R7)
        for (int i = 0; i < NV; i++) begin
            wr_reg(0, V_PRD[i]);
            wr_reg(1, V_CMP[i]);
            measure(per, hi);
            measure(per, hi);
            check($sformatf("R2 frame length vec%0d", i), per, E_PER[i]);
            check($sformatf("R5 R6 R7 high clocks vec%0d", i), hi, E_HI[i]);
        end

        // R3: mid-frame period change does not alter current frame
        wr_reg(0, 16'd9);
        wr_reg(1, 16'd4);
        measure(per, hi);
        measure(per, hi);
        wait_count(16'd3);
        wr_reg(0, 16'd19);
        mx = 0;
        while (count != '0) begin
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
        end
        check("R3 old period finishes current frame", mx, 9);
        measure(per, hi);
        check("R3 new period next frame", per, 20);

        // R4: mid-frame compare change keeps old set point this frame
        wait_count(16'd2);
        wr_reg(1, 16'd15);
        wait_count(16'd6);
        check("R4 old compare still sets output", pwm_a, 1);
        measure(per, hi);
        measure(per, hi);
        check("R4 new compare next frame", hi, 4);

        // R9: halt freezes count and output
        wait_count(16'd17);
        run_en = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 count frozen", count, 17);
        check("R9 pwm frozen", pwm_a, 1);
        run_en = 1'b1;
        @(negedge clk);
        check("R9 count resumes", count, 18);

        // R10: compare B writes are inert
        wr_reg(2, 16'd3);
        measure(per, hi);
        measure(per, hi);
        check("R10 frame length with compare B", per, 20);
        check("R10 high clocks with compare B", hi, 4);
        wr_reg(2, 16'd10);
        measure(per, hi);
        measure(per, hi);
        check("R10 high clocks with compare B moved", hi, 4);

        // R1: reset mid-run clears everything
        wait_count(16'd17);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 count after mid-run reset", count, 0);
        check("R1 pwm after mid-run reset", pwm_a, 0);
        repeat (3) @(negedge clk);
        check("R1 active period cleared", count, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule